// File: doc/BRIEF.md
# Resource Reservation Table Arbiter

This block keeps one busy bit for each shared processor resource, such as a register-file entry or a functional unit, and decides whether an issuing instruction may go ahead. An issuing instruction raises a request and presents a mask with one bit for each resource it will use. If none of those resources is busy, the block grants the request in the same cycle and marks every resource in the mask busy. If even one of them is busy, the request is stalled and the table is left as it was. Nothing is reserved in part.

A completing instruction presents a release mask, and the block clears those busy bits. A release and a request in the same cycle are resolved in that order: the release is applied first, and only then is the request checked. A resource freed in a cycle can therefore be granted again in that same cycle. Releasing a resource that is not busy does nothing to the table, and the block raises an error flag for one cycle. A synchronous clear, like reset, empties the whole table.

The table is held in one register of `NUM_RES` bits. The release stage and the grant check are combinational units that feed its next-state logic. The block has no state machine: its only state is the table itself and the registered error flag.

Top module: `rrt_arbiter`

## Requirements
- R1: After reset, every busy bit is 0 and `rel_err` is 0.
- R2: A request (`req_valid`=1, `clr`=0) is granted in the same cycle (`req_grant`=1) when no bit of `req_mask` is set in the table. The check uses the table as it stands after this cycle's release. After the next rising edge every bit of `req_mask` is set in `busy`.
- R3: A request with any bit of `req_mask` set in the table, after this cycle's release, gets `req_grant`=0. None of its mask bits becomes newly set at the next edge.
- R4: With `rel_valid`=1, every bit of `rel_mask` is 0 in `busy` after the next edge, unless a grant in the same cycle reserves that bit again.
- R5: A release and a request in the same cycle are ordered release first, so a request whose only conflicts are being released is granted in that cycle.
- R6: Releasing a bit that is not busy leaves every other bit of the table unaffected. `rel_err` is 1 in the cycle after that release and 0 in the cycle after a release with no such bit, or after a cycle with no release.
- R7: With `clr`=1, `req_grant` is 0. After the next edge every bit of `busy` is 0 and `rel_err` is 0.
- R8: With `req_valid`=0, `req_grant` is 0 and the table receives no new reservation.
- R9: A request with an all-zero `req_mask` is always granted and sets no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the whole table |
| req_valid | input | 1 | An instruction is asking to issue |
| req_mask | input | NUM_RES | Resources the issuing instruction needs, bit i = resource i |
| req_grant | output | 1 | Request accepted this cycle (combinational) |
| rel_valid | input | 1 | A completing instruction is releasing resources |
| rel_mask | input | NUM_RES | Resources being released, bit i = resource i |
| busy | output | NUM_RES | Current table, bit i = 1 when resource i is reserved |
| rel_err | output | 1 | Registered flag for a release of a resource that was not busy |

## Verification
The hardest case to reach is a request that conflicts only with resources that are being released in that same cycle. Uniform random masks almost never line up that way. The random stimulus therefore draws release masks from bits that are currently busy, and often builds the request mask from those same bits plus sparse fresh ones. Directed steps also hit the exact boundary in both directions: one remaining busy bit stalls the request, and releasing that last bit lets it through.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    localparam int unsigned RRT_DEFAULT_RES = 16;

    function automatic int unsigned rrt_count_ones(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) n += int'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/rrt_release_unit.sv
module rrt_release_unit #(
    parameter int unsigned NUM_RES = rrt_pkg::RRT_DEFAULT_RES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RES-1:0] table_q,
    input  logic               rel_valid,
    input  logic [NUM_RES-1:0] rel_mask,
    output logic [NUM_RES-1:0] table_freed,
    output logic               bad_release
);
    logic [NUM_RES-1:0] eff_rel;
    logic [NUM_RES-1:0] stray;

    always_comb begin
        eff_rel     = rel_valid ? rel_mask : '0;
        stray       = eff_rel & ~table_q;
        table_freed = table_q & ~eff_rel;
        bad_release = |stray;
    end

    // The freed view never contains a bit that was not busy before.
    AST_FREED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((table_freed & ~table_q) == '0)) else $error("freed view grew"); // R4
endmodule

// File: rtl/rrt_grant_check.sv
module rrt_grant_check #(
    parameter int unsigned NUM_RES = rrt_pkg::RRT_DEFAULT_RES
) (
    input  logic               clr,
    input  logic               req_valid,
    input  logic [NUM_RES-1:0] req_mask,
    input  logic [NUM_RES-1:0] table_freed,
    output logic               grant,
    output logic [NUM_RES-1:0] claim
);
    logic [NUM_RES-1:0] clash;

    generate
        for (genvar g = 0; g < NUM_RES; g++) begin : g_res
            assign clash[g] = req_mask[g] & table_freed[g];
        end
    endgenerate

    always_comb begin
        grant = req_valid && !clr && (clash == '0);
        claim = grant ? req_mask : '0;
    end
endmodule

// File: rtl/rrt_arbiter.sv
module rrt_arbiter #(
    parameter int unsigned NUM_RES = rrt_pkg::RRT_DEFAULT_RES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               req_valid,
    input  logic [NUM_RES-1:0] req_mask,
    output logic               req_grant,
    input  logic               rel_valid,
    input  logic [NUM_RES-1:0] rel_mask,
    output logic [NUM_RES-1:0] busy,
    output logic               rel_err
);
    logic [NUM_RES-1:0] table_q;
    logic [NUM_RES-1:0] table_freed;
    logic [NUM_RES-1:0] claim;
    logic               bad_release;
    logic               err_q;

    rrt_release_unit #(.NUM_RES(NUM_RES)) u_rel (
        .clk         (clk),
        .rst_n       (rst_n),
        .table_q     (table_q),
        .rel_valid   (rel_valid),
        .rel_mask    (rel_mask),
        .table_freed (table_freed),
        .bad_release (bad_release)
    );

    rrt_grant_check #(.NUM_RES(NUM_RES)) u_chk (
        .clr         (clr),
        .req_valid   (req_valid),
        .req_mask    (req_mask),
        .table_freed (table_freed),
        .grant       (req_grant),
        .claim       (claim)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q <= '0;
            err_q   <= 1'b0;
        end else if (clr) begin
            table_q <= '0;
            err_q   <= 1'b0;
        end else begin
            table_q <= table_freed | claim;
            err_q   <= bad_release;
        end
    end

    always_comb begin
        busy    = table_q;
        rel_err = err_q;
    end

    AST_GRANT_MARKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !clr) |=> ((busy & $past(req_mask)) == $past(req_mask))) else $error("grant partial"); // R2
    AST_STALL_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_grant) |=> ((busy & ~$past(busy)) == '0)) else $error("stall reserved"); // R3
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !clr) |=> ((busy & $past(rel_mask) & ~$past(req_grant ? req_mask : '0)) == '0)) else $error("release kept"); // R4
    AST_ERR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_valid)) else $error("spurious error"); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (busy == '0 && !rel_err)) else $error("clear incomplete"); // R7
    AST_CLEAR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !req_grant) else $error("grant in clear"); // R7
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_grant) else $error("grant idle"); // R8
endmodule

// File: tb/tb_rrt_arbiter.sv
module tb_rrt_arbiter;
    localparam int unsigned N = 16;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         req_valid = 1'b0;
    logic [N-1:0] req_mask = '0;
    logic         req_grant;
    logic         rel_valid = 1'b0;
    logic [N-1:0] rel_mask = '0;
    logic [N-1:0] busy;
    logic         rel_err;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [N-1:0] mdl = '0;
    bit           finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rrt_arbiter #(.NUM_RES(N)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .req_valid(req_valid), .req_mask(req_mask), .req_grant(req_grant),
        .rel_valid(rel_valid), .rel_mask(rel_mask),
        .busy(busy), .rel_err(rel_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_grant(input logic rv, input logic [N-1:0] rm,
                                       input logic lv, input logic [N-1:0] lm, input logic c);
        return rv && !c && ((rm & mdl & ~(lv ? lm : '0)) == '0);
    endfunction

    // Called just after a falling edge; leaves the bench just after the next one.
    task automatic step(input logic rv, input logic [N-1:0] rm, input logic lv,
                        input logic [N-1:0] lm, input logic c, input string tag);
        logic g;
        logic e;
        clr = c; req_valid = rv; req_mask = rm; rel_valid = lv; rel_mask = lm;
        #1;
        g = exp_grant(rv, rm, lv, lm, c);
        check(req_grant == g, {tag, " grant"}, 32'(req_grant), 32'(g));
        @(posedge clk);
        e   = !c && lv && ((lm & ~mdl) != '0);
        mdl = c ? '0 : ((mdl & ~(lv ? lm : '0)) | (g ? rm : '0));
        @(negedge clk);
        check(busy == mdl, {tag, " table"}, 32'(busy), 32'(mdl));
        check(rel_err == e, {tag, " err"}, 32'(rel_err), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(busy == '0, "R1 busy", 32'(busy), 32'h0);
        check(rel_err == 1'b0, "R1 err", 32'(rel_err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 16'h000F, 0, '0, 0, "R2 first grant");
        step(1, 16'h0018, 0, '0, 0, "R3 partial conflict stall");
        step(0, 16'h00F0, 0, '0, 0, "R8 idle request");
        step(1, 16'h0000, 0, '0, 0, "R9 empty mask");
        step(1, 16'h0003, 1, 16'h0001, 0, "R3 one bit still busy");
        step(1, 16'h0003, 1, 16'h0002, 0, "R5 release then grant");
        step(0, '0, 1, 16'h0C00, 0, "R6 stray release");
        step(0, '0, 0, '0, 0, "R6 err drops");
        step(0, '0, 1, 16'h0104, 0, "R6 mixed release");
        step(0, '0, 1, 16'h0008, 0, "R4 release");
        step(1, 16'hF000, 0, '0, 0, "R2 upper grant");
        step(1, 16'h0F00, 0, '0, 1, "R7 clear");
        step(0, '0, 1, 16'h0001, 1, "R7 clear masks err");

        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] rm;
            logic [N-1:0] lm;
            logic rv;
            logic lv;
            logic c;
            lm = mdl & N'($urandom);
            if ($urandom_range(0, 7) == 0) lm = lm | N'($urandom & $urandom & $urandom);
            rm = N'($urandom & $urandom & $urandom);
            if ($urandom_range(0, 2) == 0) rm = rm | lm;
            rv = ($urandom_range(0, 3) != 0);
            lv = ($urandom_range(0, 1) != 0);
            c  = ($urandom_range(0, 99) == 0);
            if (lv && rv && ((rm & mdl & ~lm) == '0) && ((rm & lm) != '0))
                step(rv, rm, lv, lm, c, "R5 random");
            else if (c)
                step(rv, rm, lv, lm, c, "R7 random");
            else if (rv)
                step(rv, rm, lv, lm, c, "R2 R3 random");
            else
                step(rv, rm, lv, lm, c, "R4 R6 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule